// File: doc/BRIEF.md
# Initiator Selection and Message-Out Builder

This block runs the initiator's part of selecting a target on a parallel SCSI-style bus after arbitration has already been won. A one-cycle `start` pulse latches the target number, the LUN, the tagging controls and the disconnect permission. The block then drives select and attention together and waits a programmable number of cycles for the target to answer with busy. Attention stays asserted through the whole selection, so the target's first information phase is message-out.

If busy never arrives, the block lets go of both bus signals and reports a failed selection with an empty message. If busy arrives, the block releases select, keeps attention up and waits for the target's first request. It then hands a one-byte or three-byte message to a separate byte-transfer engine and pulses `done`. The first byte identifies the LUN and grants or withholds disconnect permission. When tagged queuing is requested, the message also carries a simple-queue-tag code and a tag byte. In "next" mode that tag comes from a per-target counter that never issues zero.

Top module: `initiator_select_seq`

## Requirements
- R1: After reset, `sel_drv`, `atn_drv`, `done` and `fail` are low, and `msg_len`, `msg0`, `msg1`, `msg2` and `tag_used` are zero.
- R2: A `start` pulse while idle raises `sel_drv` and `atn_drv` together in the next cycle. `atn_drv` is never low while `sel_drv` is high, and `sel_drv` rises only in the cycle after a `start`.
- R3: If `bus_bsy` is not sampled high during `timeout_cycles` clock cycles of selection, then `sel_drv` and `atn_drv` drop. `done` and `fail` pulse together for one cycle, and `msg_len`, `msg0`, `msg1`, `msg2` and `tag_used` are all 0.
- R4: Once `bus_bsy` is sampled high, `sel_drv` drops in the next cycle and `atn_drv` stays high. The block then waits for `bus_req`. In the cycle after `bus_req` is sampled, `done` pulses with `fail` low and `atn_drv` drops.
- R5: `msg0` is the identify byte: bit 7 is 1, bit 6 equals the latched `disc_ok`, bits 5:3 are 0 and bits 2:0 are the latched `lun`.
- R6: A tag is requested only when `tq_en` is 1 and `tag_mode` is 2'b01 (next) or 2'b10 (explicit). Otherwise, including when `tag_mode` is 2'b00 or 2'b11, `msg_len` is 1 and `msg1`, `msg2` and `tag_used` are 0.
- R7: When a tag is requested, `msg_len` is 3, `msg1` is 8'h20 (simple queue tag), and `msg2` and `tag_used` both carry the issued tag.
- R8: In next mode the tag comes from an 8-bit counter for the latched target. A counter value of 0 is issued as 1. After a successful selection the counter holds the issued value plus 1, modulo 256. All counters reset to 0, so the tags after reset run 1, 2, …, 255, 1.
- R9: In explicit mode `tag_val` is issued as given and no counter changes.
- R10: Each target has its own counter. A selection of one target leaves the counters of all other targets unchanged.
- R11: `start` is ignored while a selection is in progress. The running selection completes with the parameters latched at its own start, and no new selection begins.
- R12: A failed selection changes no tag counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a selection |
| target | input | TGT_W | Target number to select |
| lun | input | 3 | Logical unit number |
| tq_en | input | 1 | Tagged queuing enabled for this device |
| tag_mode | input | 2 | 00 none, 01 next, 10 explicit, 11 none |
| tag_val | input | 8 | Tag value for explicit mode |
| disc_ok | input | 1 | Disconnect privilege allowed |
| timeout_cycles | input | CNT_W | Cycles to wait for busy |
| bus_bsy | input | 1 | Busy seen on the bus |
| bus_req | input | 1 | Request seen on the bus |
| sel_drv | output | 1 | Drive select |
| atn_drv | output | 1 | Drive attention |
| done | output | 1 | Selection finished (one-cycle pulse) |
| fail | output | 1 | Target did not respond (with done) |
| msg_len | output | 2 | Message length: 0, 1 or 3 |
| msg0 | output | 8 | Identify byte |
| msg1 | output | 8 | Queue-tag code byte |
| msg2 | output | 8 | Tag byte |
| tag_used | output | 8 | Tag issued for this command, 0 if none |

## Verification
The hardest state to reach is the counter wrap. A target's counter goes back to 0 only after 255 successful next-mode selections, and only then does the substitution of 1 for 0 happen a second time. The bench drives one fresh target through 255 complete busy-and-request handshakes and checks every issued tag, then checks that the 256th selection issues 1. Separate scenarios check that a timed-out selection and an explicit-mode selection leave the counter as it was: each is followed by a next-mode selection whose tag is compared against a counter model kept in the bench.

// File: rtl/isel_pkg.sv
package isel_pkg;
    localparam int TAG_W = 8;
    localparam int LUN_W = 3;
    localparam logic [TAG_W-1:0] SIMPLE_TAG_CODE = 8'h20;

    typedef enum logic [1:0] {
        TM_NONE = 2'd0,
        TM_NEXT = 2'd1,
        TM_EXPL = 2'd2,
        TM_RSVD = 2'd3
    } tag_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEL  = 2'd1,
        ST_WREQ = 2'd2
    } sel_state_e;
endpackage

// File: rtl/isel_tag_bank.sv
module isel_tag_bank
    import isel_pkg::*;
#(
    parameter int NUM_TGT = 8,
    localparam int TGT_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TGT_W-1:0] rd_tgt,
    input  logic             bump,
    output logic [TAG_W-1:0] issued
);
    logic [TAG_W-1:0] cnt_q [NUM_TGT];
    logic [TAG_W-1:0] cur;

    assign cur    = cnt_q[rd_tgt];
    // zero means "no tag", so it is never issued
    assign issued = (cur == '0) ? TAG_W'(1) : cur;

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_cnt
        logic [TAG_W-1:0] cnt_d;
        always_comb begin
            cnt_d = cnt_q[g];
            if (bump && (rd_tgt == TGT_W'(g)))
                cnt_d = issued + TAG_W'(1);
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q[g] <= '0;
            else        cnt_q[g] <= cnt_d;
        end
    end
endmodule

// File: rtl/isel_msg_build.sv
module isel_msg_build
    import isel_pkg::*;
(
    input  logic [LUN_W-1:0] lun,
    input  logic             disc_ok,
    input  logic             tag_req,
    input  logic [TAG_W-1:0] tag,
    output logic [1:0]       len,
    output logic [7:0]       b0,
    output logic [7:0]       b1,
    output logic [7:0]       b2,
    output logic [TAG_W-1:0] tag_out
);
    always_comb begin
        b0 = {1'b1, disc_ok, 3'b000, lun};
        if (tag_req) begin
            len     = 2'd3;
            b1      = SIMPLE_TAG_CODE;
            b2      = tag;
            tag_out = tag;
        end else begin
            len     = 2'd1;
            b1      = '0;
            b2      = '0;
            tag_out = '0;
        end
    end
endmodule

// File: rtl/initiator_select_seq.sv
module initiator_select_seq
    import isel_pkg::*;
#(
    parameter int NUM_TGT = 8,
    parameter int CNT_W   = 26,
    localparam int TGT_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TGT_W-1:0] target,
    input  logic [2:0]       lun,
    input  logic             tq_en,
    input  logic [1:0]       tag_mode,
    input  logic [7:0]       tag_val,
    input  logic             disc_ok,
    input  logic [CNT_W-1:0] timeout_cycles,
    input  logic             bus_bsy,
    input  logic             bus_req,
    output logic             sel_drv,
    output logic             atn_drv,
    output logic             done,
    output logic             fail,
    output logic [1:0]       msg_len,
    output logic [7:0]       msg0,
    output logic [7:0]       msg1,
    output logic [7:0]       msg2,
    output logic [7:0]       tag_used
);
    typedef struct packed {
        sel_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             sel;
        logic             atn;
        logic             done;
        logic             fail;
        logic [TGT_W-1:0] tgt;
        logic [LUN_W-1:0] lun;
        logic             tqen;
        tag_mode_e        mode;
        logic [TAG_W-1:0] tval;
        logic             disc;
        logic [1:0]       len;
        logic [7:0]       m0;
        logic [7:0]       m1;
        logic [7:0]       m2;
        logic [TAG_W-1:0] tag;
    } seq_t;

    seq_t r_q, r_d;

    logic             tag_req;
    logic             bump;
    logic [TAG_W-1:0] bank_tag;
    logic [TAG_W-1:0] chosen_tag;
    logic [1:0]       b_len;
    logic [7:0]       b_m0, b_m1, b_m2;
    logic [TAG_W-1:0] b_tag;
    logic             timed_out;

    assign tag_req    = r_q.tqen && ((r_q.mode == TM_NEXT) || (r_q.mode == TM_EXPL));
    assign chosen_tag = (r_q.mode == TM_NEXT) ? bank_tag : r_q.tval;
    assign bump       = (r_q.st == ST_WREQ) && bus_req && tag_req && (r_q.mode == TM_NEXT);
    assign timed_out  = ({1'b0, r_q.cnt} + (CNT_W+1)'(1)) >= {1'b0, timeout_cycles};

    isel_tag_bank #(.NUM_TGT(NUM_TGT)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_tgt (r_q.tgt),
        .bump   (bump),
        .issued (bank_tag)
    );

    isel_msg_build u_build (
        .lun     (r_q.lun),
        .disc_ok (r_q.disc),
        .tag_req (tag_req),
        .tag     (chosen_tag),
        .len     (b_len),
        .b0      (b_m0),
        .b1      (b_m1),
        .b2      (b_m2),
        .tag_out (b_tag)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_SEL;
                    r_d.sel  = 1'b1;
                    r_d.atn  = 1'b1;
                    r_d.cnt  = '0;
                    r_d.tgt  = target;
                    r_d.lun  = lun;
                    r_d.tqen = tq_en;
                    r_d.mode = tag_mode_e'(tag_mode);
                    r_d.tval = tag_val;
                    r_d.disc = disc_ok;
                end
            end
            ST_SEL: begin
                if (bus_bsy) begin
                    r_d.st  = ST_WREQ;
                    r_d.sel = 1'b0;
                end else if (timed_out) begin
                    r_d.st   = ST_IDLE;
                    r_d.sel  = 1'b0;
                    r_d.atn  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.fail = 1'b1;
                    r_d.len  = '0;
                    r_d.m0   = '0;
                    r_d.m1   = '0;
                    r_d.m2   = '0;
                    r_d.tag  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_WREQ: begin
                if (bus_req) begin
                    r_d.st   = ST_IDLE;
                    r_d.atn  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.len  = b_len;
                    r_d.m0   = b_m0;
                    r_d.m1   = b_m1;
                    r_d.m2   = b_m2;
                    r_d.tag  = b_tag;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.mode <= TM_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_drv  = r_q.sel;
    assign atn_drv  = r_q.atn;
    assign done     = r_q.done;
    assign fail     = r_q.fail;
    assign msg_len  = r_q.len;
    assign msg0     = r_q.m0;
    assign msg1     = r_q.m1;
    assign msg2     = r_q.m2;
    assign tag_used = r_q.tag;
endmodule

// File: rtl/isel_chk.sv
module isel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       bus_req,
    input logic       sel_drv,
    input logic       atn_drv,
    input logic       done,
    input logic       fail,
    input logic [1:0] msg_len,
    input logic [7:0] msg0
);
    // R2
    sel_needs_atn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_drv |-> atn_drv);

    // R2
    sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_drv) |-> $past(start));

    // R3
    fail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (done && !sel_drv && !atn_drv && msg_len == 2'd0));

    // R4
    done_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> $past(bus_req));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    ident_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (msg0[7] && msg0[5:3] == 3'b000
                             && (msg_len == 2'd1 || msg_len == 2'd3)));
endmodule

bind initiator_select_seq isel_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .bus_req (bus_req),
    .sel_drv (sel_drv),
    .atn_drv (atn_drv),
    .done    (done),
    .fail    (fail),
    .msg_len (msg_len),
    .msg0    (msg0)
);

// File: tb/initiator_select_seq_bench.sv
module initiator_select_seq_bench;
    localparam int NUM_TGT = 8;
    localparam int CNT_W   = 26;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] target = '0;
    logic [2:0] lun = '0;
    logic       tq_en = 1'b0;
    logic [1:0] tag_mode = '0;
    logic [7:0] tag_val = '0;
    logic       disc_ok = 1'b0;
    logic [CNT_W-1:0] timeout_cycles = CNT_W'(20);
    logic       bus_bsy = 1'b0;
    logic       bus_req = 1'b0;
    logic       sel_drv, atn_drv, done, fail;
    logic [1:0] msg_len;
    logic [7:0] msg0, msg1, msg2, tag_used;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int model_cnt [NUM_TGT];

    always #2 clk = ~clk;

    initiator_select_seq #(.NUM_TGT(NUM_TGT), .CNT_W(CNT_W)) u_initiator_select_seq (
        .clk, .rst_n, .start, .target, .lun, .tq_en, .tag_mode, .tag_val,
        .disc_ok, .timeout_cycles, .bus_bsy, .bus_req, .sel_drv, .atn_drv,
        .done, .fail, .msg_len, .msg0, .msg1, .msg2, .tag_used
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int next_tag(input int t);
        int iss;
        iss = (model_cnt[t] == 0) ? 1 : model_cnt[t];
        model_cnt[t] = (iss + 1) % 256;
        return iss;
    endfunction

    // complete handshake: busy two cycles after select, request one cycle after busy seen
    task automatic run_sel(input int tgt, input int ln, input bit tq, input int mode,
                           input int val, input bit disc);
        @(negedge clk);
        start = 1; target = 3'(tgt); lun = 3'(ln); tq_en = tq;
        tag_mode = 2'(mode); tag_val = 8'(val); disc_ok = disc;
        @(negedge clk);
        start = 0;
        chk(sel_drv && atn_drv, "R2 sel+atn after start", {sel_drv, atn_drv}, 3);
        @(negedge clk);
        bus_bsy = 1;
        @(negedge clk);
        chk(!sel_drv && atn_drv && !done, "R4 sel drops atn held", {done, sel_drv, atn_drv}, 1);
        bus_req = 1;
        @(negedge clk);
        chk(done && !fail && !atn_drv, "R4 done after req", {done, fail, atn_drv}, 4);
        bus_bsy = 0; bus_req = 0;
    endtask

    task automatic t_reset();
        chk(!sel_drv && !atn_drv && !done && !fail, "R1 reset controls",
            {sel_drv, atn_drv, done, fail}, 0);
        chk(msg_len == 0 && msg0 == 0 && msg1 == 0 && msg2 == 0 && tag_used == 0,
            "R1 reset message", {msg_len, msg0}, 0);
    endtask

    task automatic t_no_tag();
        run_sel(1, 5, 0, 1, 0, 1);
        chk(msg0 == 8'hC5, "R5 identify disc=1 lun=5", msg0, 8'hC5);
        chk(msg_len == 1 && msg1 == 0 && msg2 == 0 && tag_used == 0, "R6 tq_en low",
            {msg_len, tag_used}, 32'h100);
        run_sel(1, 2, 1, 0, 0, 0);
        chk(msg0 == 8'h82, "R5 identify disc=0 lun=2", msg0, 8'h82);
        chk(msg_len == 1 && tag_used == 0, "R6 mode none", {msg_len, tag_used}, 32'h100);
        run_sel(1, 7, 1, 3, 8'h44, 1);
        chk(msg_len == 1 && msg1 == 0 && tag_used == 0, "R6 mode 11", {msg_len, tag_used}, 32'h100);
    endtask

    task automatic t_next();
        for (int i = 0; i < 3; i++) begin
            int e;
            e = next_tag(0);
            run_sel(0, 1, 1, 1, 0, 1);
            chk(msg_len == 3 && msg1 == 8'h20, "R7 tag message", {msg_len, msg1}, 32'h320);
            chk(msg2 == 8'(e) && tag_used == 8'(e), "R8 next tag", tag_used, e);
        end
    endtask

    task automatic t_explicit();
        int e;
        run_sel(0, 3, 1, 2, 8'hA7, 0);
        chk(msg_len == 3 && msg2 == 8'hA7 && tag_used == 8'hA7, "R9 explicit tag", tag_used, 8'hA7);
        e = next_tag(0);
        run_sel(0, 3, 1, 1, 0, 0);
        chk(tag_used == 8'(e), "R9 counter unchanged by explicit", tag_used, e);
    endtask

    task automatic t_independent();
        int e;
        e = next_tag(4);
        run_sel(4, 0, 1, 1, 0, 0);
        chk(tag_used == 8'(e), "R10 fresh target starts at 1", tag_used, e);
        e = next_tag(0);
        run_sel(0, 0, 1, 1, 0, 0);
        chk(tag_used == 8'(e), "R10 other target kept", tag_used, e);
    endtask

    task automatic t_timeout();
        int hi;
        int e;
        timeout_cycles = CNT_W'(5);
        @(negedge clk);
        start = 1; target = 3'd4; tq_en = 1; tag_mode = 2'd1;
        @(negedge clk);
        start = 0;
        hi = 0;
        for (int k = 0; k < 50 && !done; k++) begin
            if (sel_drv) hi++;
            @(negedge clk);
        end
        chk(hi == 5, "R3 selection window length", hi, 5);
        chk(done && fail && !sel_drv && !atn_drv, "R3 fail released", {done, fail, sel_drv, atn_drv}, 12);
        chk(msg_len == 0 && msg0 == 0 && msg1 == 0 && msg2 == 0 && tag_used == 0,
            "R3 empty message", {msg_len, msg0}, 0);
        @(negedge clk);
        chk(!done && !fail, "R3 one-cycle pulse", {done, fail}, 0);
        timeout_cycles = CNT_W'(20);
        e = next_tag(4);
        run_sel(4, 0, 1, 1, 0, 0);
        chk(tag_used == 8'(e), "R12 counter unchanged by fail", tag_used, e);
    endtask

    task automatic t_busy_ignore();
        int e;
        e = next_tag(2);
        @(negedge clk);
        start = 1; target = 3'd2; lun = 3'd6; tq_en = 1; tag_mode = 2'd1; disc_ok = 0;
        @(negedge clk);
        start = 0;
        bus_bsy = 1;
        @(negedge clk);
        start = 1; target = 3'd6; lun = 3'd1; tag_mode = 2'd2; tag_val = 8'h55; disc_ok = 1;
        @(negedge clk);
        start = 0;
        bus_req = 1;
        @(negedge clk);
        bus_bsy = 0; bus_req = 0;
        chk(done && msg0 == 8'h86, "R11 latched lun kept", msg0, 8'h86);
        chk(tag_used == 8'(e), "R11 latched target kept", tag_used, e);
        @(negedge clk);
        chk(!sel_drv && !atn_drv, "R11 no second selection", {sel_drv, atn_drv}, 0);
        e = next_tag(6);
        run_sel(6, 0, 1, 1, 0, 0);
        chk(tag_used == 8'(e), "R11 ignored start left target 6 alone", tag_used, e);
    endtask

    task automatic t_wrap();
        int bad;
        int e;
        bad = 0;
        for (int i = 1; i <= 255; i++) begin
            e = next_tag(7);
            run_sel(7, 0, 1, 1, 0, 0);
            if (tag_used != 8'(i) || e != i) begin
                bad++;
                if (bad == 1) chk(0, "R8 sequence", tag_used, i);
            end
        end
        chk(bad == 0, "R8 tags 1..255", bad, 0);
        e = next_tag(7);
        run_sel(7, 0, 1, 1, 0, 0);
        chk(tag_used == 8'd1 && e == 1, "R8 wrap skips zero", tag_used, 1);
    endtask

    initial begin
        for (int t = 0; t < NUM_TGT; t++) model_cnt[t] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_no_tag();
        t_next();
        t_explicit();
        t_independent();
        t_timeout();
        t_busy_ignore();
        t_wrap();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule